// File: doc/BRIEF.md
# Locked Indirect Register Bank Port

This block sits behind a management interface and exposes three host-visible registers: a control word, a staging register for outbound data, and a result register for returned data. Behind them lie four hidden banks of 32 sixteen-bit words. The host reaches these banks only indirectly. It packs a direction flag, a bank number and a word address into one control write.

Bank access starts out locked. To open it, the host writes the control register with a fixed four-step pattern. Once the banks are open, each control write that carries exactly one direction flag performs one transfer. For a bank write, the host first loads the staging register and then issues the control word; the staged value is stored. For a bank read, the control word copies the addressed word into the result register, where the host reads it back. Writing zero to the control register locks the banks again.

The host port is a plain synchronous register port: one write strobe, a 2-bit register select, write data, and combinational read data for the selected register.

Top module: `mgmt_bank_regs`

## Requirements
- R1: After reset, the control, staging and result registers all read 0x0000, and every bank word holds zero.
- R2: Host register select 0 is the control register, 1 is the staging register, 2 is the result register and 3 always reads zero. A write to select 0 or 1 stores the data, readable from the next cycle. Host writes to select 2 or 3 change nothing.
- R3: Control word fields are as follows. Bit 15 requests a bank read. Bit 14 requests a bank write. Bits 12:11 pick the bank. Bit 10 is the test-mode flag. Bits 9:5 give the read address and bits 4:0 give the write address.
- R4: The banks open only after four consecutive control writes of 0x0000, 0x0400, 0x0000 and 0x0400.
- R5: A control write that does not continue the unlock pattern returns the tracker to idle. A 0x0000 write always counts as the first step of a new attempt.
- R6: While the banks are locked, read and write requests are ignored. No bank word and no result register value changes.
- R7: When the banks are open, a control write with only bit 14 set among bits 15:14 stores the staging register into the addressed word of the selected bank. The write address comes from bits 4:0.
- R8: When the banks are open, a control write with only bit 15 set among bits 15:14 loads the result register from the addressed word of the selected bank. The read address comes from bits 9:5. The result is readable on the next cycle.
- R9: A control word with both bits 15 and 14 set is a no-op. Banks and the result register stay unchanged.
- R10: A control write of 0x0000 locks the banks again.
- R11: Each bank is a separate array: the same address in different banks holds independent values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 2 | Host register select |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Contents of the selected host register |

## Verification
The assertions assume that the host write data is stable and known whenever the write strobe is high. They also assume that a control write is the only event that can move the unlock tracker or the result register. The stimulus drives every input at the falling edge from a single task and holds it for a full cycle, so each strobe lasts exactly one clock. Each transfer is issued in its own cycle, after its staging value has landed. Locked, broken-pattern, both-flag and relock cases are all placed between full unlock sequences, so the tracker state going into every check is known.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  localparam int unsigned DW       = 16;
  localparam int          RD_BIT   = 15;
  localparam int          WR_BIT   = 14;
  localparam int          BANK_LO  = 11;
  localparam int          TEST_BIT = 10;
  localparam int          RADDR_LO = 5;
  localparam int          WADDR_LO = 0;
  localparam logic [DW-1:0] TEST_ONLY = DW'(1) << TEST_BIT;

  typedef enum logic [2:0] {
    LK_IDLE, LK_Z1, LK_T1, LK_Z2, LK_OPEN
  } lock_e;

  typedef enum logic [1:0] {
    HA_CTRL  = 2'd0,
    HA_WDATA = 2'd1,
    HA_RDATA = 2'd2,
    HA_NONE  = 2'd3
  } haddr_e;
endpackage

// File: rtl/lock_seq.sv
module lock_seq
  import mbr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [DW-1:0] ctrl_val_i,
  output logic          open_o
);
  lock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ctrl_we_i) begin
      if (ctrl_val_i == '0) begin
        // zero relocks or restarts; only completes step three from T1
        state_d = (state_q == LK_T1) ? LK_Z2 : LK_Z1;
      end else if (ctrl_val_i == TEST_ONLY) begin
        unique case (state_q)
          LK_Z1:   state_d = LK_T1;
          LK_Z2:   state_d = LK_OPEN;
          LK_OPEN: state_d = LK_OPEN;
          default: state_d = LK_IDLE;
        endcase
      end else begin
        state_d = (state_q == LK_OPEN) ? LK_OPEN : LK_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_IDLE;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == LK_OPEN);

  AST_ZERO_RELOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_val_i == '0) |=> !open_o); // R10

  AST_OPEN_AFTER_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(ctrl_we_i && ctrl_val_i == TEST_ONLY)); // R4
endmodule

// File: rtl/bank_file.sv
module bank_file
  import mbr_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wbank_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [BANK_W-1:0] rbank_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int BANKS = 1 << BANK_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] words [BANKS];
  logic [BANKS-1:0] we_vec;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    assign we_vec[b] = we_i && (wbank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we_vec[b]) begin
        mem[waddr_i] <= wdata_i;
      end
    end

    assign words[b] = mem[raddr_i];
  end

  assign rdata_o = words[rbank_i];

  AST_ONE_BANK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_vec)); // R11
endmodule

// File: rtl/mgmt_bank_regs.sv
module mgmt_bank_regs
  import mbr_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [1:0]    host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o
);
  logic [DW-1:0] ctrl_q, wdata_q, rdata_q, bank_word;
  logic          ctrl_we, open, rd_req, wr_req, xfer_ok, bank_we, bank_re;
  logic [BANK_W-1:0] sel_bank;
  logic [ADDR_W-1:0] rd_addr, wr_addr;

  assign ctrl_we  = host_we_i && (host_addr_i == HA_CTRL);
  assign rd_req   = host_wdata_i[RD_BIT];
  assign wr_req   = host_wdata_i[WR_BIT];
  assign sel_bank = host_wdata_i[BANK_LO +: BANK_W];
  assign rd_addr  = host_wdata_i[RADDR_LO +: ADDR_W];
  assign wr_addr  = host_wdata_i[WADDR_LO +: ADDR_W];

  // exactly one direction flag; both set is a no-op
  assign xfer_ok = ctrl_we && open && (rd_req ^ wr_req);
  assign bank_we = xfer_ok && wr_req;
  assign bank_re = xfer_ok && rd_req;

  lock_seq u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we),
    .ctrl_val_i (host_wdata_i),
    .open_o     (open)
  );

  bank_file #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_banks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bank_we),
    .wbank_i (sel_bank),
    .waddr_i (wr_addr),
    .wdata_i (wdata_q),
    .rbank_i (sel_bank),
    .raddr_i (rd_addr),
    .rdata_o (bank_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= host_wdata_i;
      if (host_we_i && host_addr_i == HA_WDATA) wdata_q <= host_wdata_i;
      if (bank_re) rdata_q <= bank_word;
    end
  end

  always_comb begin
    unique case (host_addr_i)
      HA_CTRL:  host_rdata_o = ctrl_q;
      HA_WDATA: host_rdata_o = wdata_q;
      HA_RDATA: host_rdata_o = rdata_q;
      default:  host_rdata_o = '0;
    endcase
  end

  AST_LOCKED_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && !open) |=> $stable(rdata_q)); // R6

  AST_BOTH_FLAGS_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && rd_req && wr_req) |=> $stable(rdata_q)); // R9

  AST_RESULT_ONLY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_we && rd_req) |=> $stable(rdata_q)); // R8
endmodule

// File: tb/tb_mgmt_bank_regs.sv
`timescale 1ns/1ps
module tb_mgmt_bank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;

  int checks = 0;
  int errors = 0;
  string last_tag = "R1";

  // reference model
  int m_bank [4][32];
  int m_ctrl, m_wdata, m_rdata;
  int m_state; // 0 idle,1 z1,2 t1,3 z2,4 open

  always #2 clk = ~clk;

  mgmt_bank_regs dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .host_we_i    (host_we),
    .host_addr_i  (host_addr),
    .host_wdata_i (host_wdata),
    .host_rdata_o (host_rdata)
  );

  task automatic check(input string tag);
    int exp;
    case (host_addr)
      2'd0:    exp = m_ctrl;
      2'd1:    exp = m_wdata;
      2'd2:    exp = m_rdata;
      default: exp = 0;
    endcase
    checks++;
    if (host_rdata !== 16'(exp)) begin
      errors++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", tag, host_addr, host_rdata, 16'(exp));
    end
  endtask

  task automatic model(input bit we, input logic [1:0] a, input logic [15:0] d);
    if (!we) return;
    if (a == 2'd1) m_wdata = d;
    if (a == 2'd0) begin
      m_ctrl = d;
      if (m_state == 4 && (d[15] != d[14])) begin
        if (d[14]) m_bank[d[12:11]][d[4:0]] = m_wdata;
        else       m_rdata = m_bank[d[12:11]][d[9:5]];
      end
      if (d == 16'h0)          m_state = (m_state == 2) ? 3 : 1;
      else if (d == 16'h0400)  m_state = (m_state == 1) ? 2 : (m_state == 3 || m_state == 4) ? 4 : 0;
      else                     m_state = (m_state == 4) ? 4 : 0;
    end
  endtask

  task automatic step(input bit we, input logic [1:0] a, input logic [15:0] d, input string tag);
    @(negedge clk);
    check(last_tag);
    host_we = we; host_addr = a; host_wdata = d;
    model(we, a, d);
    last_tag = tag;
  endtask

  task automatic unlock(input string tag);
    step(1, 0, 16'h0000, tag);
    step(1, 0, 16'h0400, tag);
    step(1, 0, 16'h0000, tag);
    step(1, 0, 16'h0400, tag);
  endtask

  task automatic bwrite(input logic [1:0] b, input logic [4:0] ad, input logic [15:0] v, input string tag);
    step(1, 1, v, tag);
    step(1, 0, {2'b01, 1'b0, b, 1'b1, 5'd0, ad}, tag);
  endtask

  task automatic bread(input logic [1:0] b, input logic [4:0] ad, input string tag);
    step(1, 0, {2'b10, 1'b0, b, 1'b1, ad, 5'd0}, tag);
    step(0, 2, 16'h0, tag);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) for (int i = 0; i < 32; i++) m_bank[b][i] = 0;
    m_ctrl = 0; m_wdata = 0; m_rdata = 0; m_state = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    step(0, 0, 0, "R1"); step(0, 1, 0, "R1"); step(0, 2, 0, "R1"); step(0, 3, 0, "R1");
    // R2 host map
    step(1, 1, 16'hBEEF, "R2"); step(0, 1, 0, "R2");
    step(1, 2, 16'hFFFF, "R2"); step(0, 2, 0, "R2");
    step(1, 3, 16'h1234, "R2"); step(0, 3, 0, "R2");
    step(1, 0, 16'h1234, "R2"); step(0, 0, 0, "R2");
    // R6 locked requests ignored
    bwrite(2'd1, 5'd3, 16'h1111, "R6");
    bread(2'd1, 5'd3, "R6");
    unlock("R4");
    bread(2'd1, 5'd3, "R6");
    // R10 relock then locked write ignored
    step(1, 0, 16'h0000, "R10");
    bwrite(2'd0, 5'd7, 16'h7777, "R10");
    unlock("R10");
    bread(2'd0, 5'd7, "R10");
    // R5 broken pattern
    step(1, 0, 16'h0000, "R5"); step(1, 0, 16'h0400, "R5");
    step(1, 0, 16'h0001, "R5"); step(1, 0, 16'h0400, "R5");
    bwrite(2'd0, 5'd1, 16'h2222, "R5");
    step(1, 0, 16'h0000, "R5"); step(1, 0, 16'h0400, "R5");
    step(1, 0, 16'h0400, "R5"); step(1, 0, 16'h0400, "R5");
    bwrite(2'd0, 5'd1, 16'h3333, "R5");
    // R5 repeated zero restarts
    step(1, 0, 16'h0000, "R5"); step(1, 0, 16'h0000, "R5");
    step(1, 0, 16'h0400, "R5"); step(1, 0, 16'h0000, "R5"); step(1, 0, 16'h0400, "R5");
    bread(2'd0, 5'd1, "R5");
    // R7 R8 R11 R3
    bwrite(2'd0, 5'd5, 16'hA5A5, "R7");
    bwrite(2'd2, 5'd5, 16'h5A5A, "R11");
    bwrite(2'd3, 5'd31, 16'hC3C3, "R3");
    bread(2'd0, 5'd5, "R8");
    bread(2'd2, 5'd5, "R11");
    bread(2'd1, 5'd5, "R11");
    bread(2'd3, 5'd31, "R3");
    // R9 both flags
    bread(2'd0, 5'd5, "R9");
    step(1, 1, 16'h9999, "R9");
    step(1, 0, {2'b11, 1'b0, 2'd0, 1'b1, 5'd6, 5'd5}, "R9");
    step(0, 2, 0, "R9");
    bread(2'd0, 5'd5, "R9");
    step(0, 2, 0, "R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule